// File: doc/BRIEF.md
# Memory-Mapped Control Register Responder

This block sits on the host-to-device register path of an accelerator. The host issues register reads and writes as memory-mapped requests. Each request arrives as a 28-bit header, a read strobe or a write strobe, and a wide write-data bus. The block holds a small bank of 64-bit control registers, one sticky status word and a read-only identification area. Every read is answered one cycle later on a response channel that cannot push back, so the block takes a new request on every cycle and never stalls.

The header packs a 16-bit dword address (byte address divided by four), a 2-bit length code and a 9-bit tag. A read echoes the tag in its response. Writes are posted and get no response. Two 32-bit dwords make up each 64-bit register, and the address's low bit picks which one a 4-byte access touches. An 8-byte access must start on an even dword. If it does not, the access is dropped and a sticky error bit is set. A read that is dropped this way still gets its response.

Top module: `mmio_regfile_resp`

## Requirements
- R1: While and after reset, with no request, `rsp_valid` is 0. After reset every control register and the sticky error bit read as 0.
- R2: A cycle with `rd_valid` high gives exactly one response in the next cycle, and `rsp_tag` equals header bits [8:0] of that read. A cycle with only `wr_valid` high, or with no strobe, gives no response in the next cycle. The two strobes are never high together.
- R3: A read with length code 0 (4 bytes) returns one dword on `rsp_data[31:0]` with bits [63:32] zero. An even dword address selects register bits [31:0] and an odd one selects bits [63:32].
- R4: A read with length code 1 (8 bytes) at an even dword address returns the full 64-bit register.
- R5: A write with length code 0 takes `wdata[31:0]`. At an even dword address it replaces register bits [31:0], and at an odd one it replaces bits [63:32]. The other half of the register is unchanged.
- R6: A write with length code 1 at an even dword address replaces the whole register with `wdata[63:0]`.
- R7: An 8-byte access at an odd dword address changes no register and sets the sticky error bit. That bit reads as bit 0 of the status word and stays set until reset. An 8-byte read at an odd dword address returns zero data.
- R8: Control register i sits at dword addresses 2i and 2i+1. The status word sits at dword 16 and 17. A read of an address with nothing behind it returns zero. Writes to the status word, the identification area or an unmapped address change nothing that can be read back.
- R9: Dword addresses 32 and 33 read the constant `ID_LO`, and dword addresses 34 and 35 read the constant `ID_HI`.
- R10: A write with length code 2 (64 bytes) or 3 changes no register. A read with length code 2 or 3 still responds, with zero data.
- R11: Requests on consecutive cycles are each handled. A read issued the cycle after a write to the same register returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_valid | input | 1 | Read request strobe |
| wr_valid | input | 1 | Write request strobe |
| hdr | input | 28 | Request header: dword address [27:12], length code [11:10], reserved bit [9], tag [8:0] |
| wdata | input | 512 | Write data; only bits [63:0] are used |
| rsp_valid | output | 1 | Read response strobe |
| rsp_tag | output | 9 | Tag echoed from the read request |
| rsp_data | output | 64 | Read response data |

## Verification
The assertions check on every cycle the one-to-one link between read strobes and responses, the tag echo, and the zero upper half of 4-byte responses. They also check that odd-address 8-byte reads and reads with length code 2 or 3 return zero data, and that the error bit never clears once set. Register contents can only be shown by the bench's scenarios: half-register updates, full updates, writes that are dropped because of misalignment, length or target, the identification constants, and write-then-read on back-to-back cycles.

// File: rtl/mmio_rf_pkg.sv
package mmio_rf_pkg;

    localparam int HDR_W  = 28;
    localparam int TAG_W  = 9;
    localparam int DWA_W  = 16;
    localparam int QWA_W  = DWA_W - 1;
    localparam int REG_W  = 64;
    localparam int HALF_W = REG_W / 2;

    typedef enum logic [1:0] {
        SZ_DWORD = 2'd0,
        SZ_QWORD = 2'd1,
        SZ_LINE  = 2'd2,
        SZ_RSVD  = 2'd3
    } size_e;

    typedef struct packed {
        logic [QWA_W-1:0] qw_idx;
        logic             hi_half;
        size_e            size;
        logic [TAG_W-1:0] tag;
        logic             misalign;
    } req_dec_t;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [REG_W-1:0] data;
    } rsp_t;

endpackage

// File: rtl/mmio_hdr_decode.sv
module mmio_hdr_decode
    import mmio_rf_pkg::*;
(
    input  logic [HDR_W-1:0] hdr,
    output req_dec_t         dec
);

    localparam int TAG_LSB  = 0;
    localparam int SIZE_LSB = 10;
    localparam int DWA_LSB  = 12;

    logic [DWA_W-1:0] dw_addr;

    always_comb begin
        dw_addr      = hdr[DWA_LSB +: DWA_W];
        dec.qw_idx   = dw_addr[DWA_W-1:1];
        dec.hi_half  = dw_addr[0];
        dec.size     = size_e'(hdr[SIZE_LSB +: 2]);
        dec.tag      = hdr[TAG_LSB +: TAG_W];
        dec.misalign = (dec.size == SZ_QWORD) && dw_addr[0];
    end

endmodule

// File: rtl/mmio_reg_bank.sv
module mmio_reg_bank
    import mmio_rf_pkg::*;
#(
    parameter int NUM_REGS = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           rd_valid,
    input  logic                           wr_valid,
    input  req_dec_t                       dec,
    input  logic [REG_W-1:0]               wdata,
    output logic [NUM_REGS-1:0][REG_W-1:0] regs,
    output logic                           err
);

    logic [NUM_REGS-1:0][REG_W-1:0] regs_d, regs_q;
    logic                           err_d, err_q;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic sel;

        always_comb begin
            sel       = wr_valid && (dec.qw_idx == QWA_W'(i));
            regs_d[i] = regs_q[i];
            if (sel && dec.size == SZ_DWORD) begin
                if (dec.hi_half) regs_d[i][REG_W-1:HALF_W] = wdata[HALF_W-1:0];
                else             regs_d[i][HALF_W-1:0]     = wdata[HALF_W-1:0];
            end else if (sel && dec.size == SZ_QWORD && !dec.misalign) begin
                regs_d[i] = wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) regs_q[i] <= '0;
            else     regs_q[i] <= regs_d[i];
        end
    end

    always_comb begin
        err_d = err_q | ((rd_valid | wr_valid) & dec.misalign);
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= err_d;
    end

    assign regs = regs_q;
    assign err  = err_q;

endmodule

// File: rtl/mmio_rd_mux.sv
module mmio_rd_mux
    import mmio_rf_pkg::*;
#(
    parameter int               NUM_REGS = 4,
    parameter int               STAT_QW  = 8,
    parameter int               ID_QW    = 16,
    parameter logic [REG_W-1:0] ID_LO    = 64'h5A17_C0DE_0000_0001,
    parameter logic [REG_W-1:0] ID_HI    = 64'h0000_0000_F00D_BEEF
) (
    input  req_dec_t                       dec,
    input  logic [NUM_REGS-1:0][REG_W-1:0] regs,
    input  logic                           err,
    output logic [REG_W-1:0]               rd_data
);

    logic [REG_W-1:0] qword;

    always_comb begin
        qword = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (dec.qw_idx == QWA_W'(i)) qword = regs[i];
        end
        if (dec.qw_idx == QWA_W'(STAT_QW))   qword = {{(REG_W-1){1'b0}}, err};
        if (dec.qw_idx == QWA_W'(ID_QW))     qword = ID_LO;
        if (dec.qw_idx == QWA_W'(ID_QW + 1)) qword = ID_HI;

        unique case (dec.size)
            SZ_DWORD: rd_data = {{HALF_W{1'b0}},
                                 dec.hi_half ? qword[REG_W-1:HALF_W] : qword[HALF_W-1:0]};
            SZ_QWORD: rd_data = dec.misalign ? '0 : qword;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/mmio_regfile_resp.sv
module mmio_regfile_resp
    import mmio_rf_pkg::*;
#(
    parameter int               NUM_REGS = 4,
    parameter int               WDATA_W  = 512,
    parameter int               STAT_QW  = 8,
    parameter int               ID_QW    = 16,
    parameter logic [REG_W-1:0] ID_LO    = 64'h5A17_C0DE_0000_0001,
    parameter logic [REG_W-1:0] ID_HI    = 64'h0000_0000_F00D_BEEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_valid,
    input  logic               wr_valid,
    input  logic [HDR_W-1:0]   hdr,
    input  logic [WDATA_W-1:0] wdata,
    output logic               rsp_valid,
    output logic [TAG_W-1:0]   rsp_tag,
    output logic [REG_W-1:0]   rsp_data
);

    req_dec_t                       dec;
    logic [NUM_REGS-1:0][REG_W-1:0] regs;
    logic                           err_flag;
    logic [REG_W-1:0]               rd_data;
    rsp_t                           rsp_d, rsp_q;
    logic                           unused_bits;

    assign unused_bits = ^{wdata[WDATA_W-1:REG_W], hdr[9]};

    mmio_hdr_decode u_dec (
        .hdr (hdr),
        .dec (dec)
    );

    mmio_reg_bank #(
        .NUM_REGS (NUM_REGS)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .rd_valid (rd_valid),
        .wr_valid (wr_valid),
        .dec      (dec),
        .wdata    (wdata[REG_W-1:0]),
        .regs     (regs),
        .err      (err_flag)
    );

    mmio_rd_mux #(
        .NUM_REGS (NUM_REGS),
        .STAT_QW  (STAT_QW),
        .ID_QW    (ID_QW),
        .ID_LO    (ID_LO),
        .ID_HI    (ID_HI)
    ) u_mux (
        .dec     (dec),
        .regs    (regs),
        .err     (err_flag),
        .rd_data (rd_data)
    );

    always_comb begin
        rsp_d.valid = rd_valid;
        rsp_d.tag   = rd_valid ? dec.tag : '0;
        rsp_d.data  = rd_valid ? rd_data : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_tag   = rsp_q.tag;
    assign rsp_data  = rsp_q.data;

endmodule

// File: rtl/mmio_rf_chk.sv
module mmio_rf_chk
    import mmio_rf_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             rd_valid,
    input logic             wr_valid,
    input logic [HDR_W-1:0] hdr,
    input logic             rsp_valid,
    input logic [TAG_W-1:0] rsp_tag,
    input logic [REG_W-1:0] rsp_data,
    input logic             err_flag
);

    logic live_q;

    always_ff @(posedge clk) begin
        if (rst) live_q <= 1'b0;
        else     live_q <= 1'b1;
    end

    // R2
    excl_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_valid && wr_valid));

    // R2
    rsp_follows_rd_chk: assert property (@(posedge clk) disable iff (rst)
        live_q && rd_valid |=> rsp_valid && (rsp_tag == $past(hdr[8:0])));

    // R2
    no_rsp_without_rd_chk: assert property (@(posedge clk) disable iff (rst)
        live_q && !rd_valid |=> !rsp_valid);

    // R3
    dword_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        live_q && rd_valid && hdr[11:10] == 2'd0 |=> rsp_data[63:32] == 32'd0);

    // R7
    misalign_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        live_q && rd_valid && hdr[11:10] == 2'd1 && hdr[12] |=> rsp_data == '0);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    // R10
    wide_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        live_q && rd_valid && hdr[11] |=> rsp_valid && rsp_data == '0);

endmodule

bind mmio_regfile_resp mmio_rf_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_valid  (rd_valid),
    .wr_valid  (wr_valid),
    .hdr       (hdr),
    .rsp_valid (rsp_valid),
    .rsp_tag   (rsp_tag),
    .rsp_data  (rsp_data),
    .err_flag  (err_flag)
);

// File: tb/sim_mmio_regfile_resp.sv
module sim_mmio_regfile_resp;

    localparam logic [63:0] ID_LO = 64'h5A17_C0DE_0000_0001;
    localparam logic [63:0] ID_HI = 64'h0000_0000_F00D_BEEF;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         rd_valid = 1'b0;
    logic         wr_valid = 1'b0;
    logic [27:0]  hdr = '0;
    logic [511:0] wdata = '0;
    logic         rsp_valid;
    logic [8:0]   rsp_tag;
    logic [63:0]  rsp_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    mmio_regfile_resp u0 (
        .clk       (clk),
        .rst       (rst),
        .rd_valid  (rd_valid),
        .wr_valid  (wr_valid),
        .hdr       (hdr),
        .wdata     (wdata),
        .rsp_valid (rsp_valid),
        .rsp_tag   (rsp_tag),
        .rsp_data  (rsp_data)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put(bit rd, bit wr, logic [15:0] a, logic [1:0] l,
                       logic [8:0] t, logic [63:0] d);
        rd_valid = rd;
        wr_valid = wr;
        hdr      = {a, l, 1'b0, t};
        wdata    = {{448{1'b1}}, d};
    endtask

    task automatic idle();
        rd_valid = 1'b0;
        wr_valid = 1'b0;
        hdr      = '0;
        wdata    = '0;
    endtask

    // One read; checks valid and tag echo, returns data.
    task automatic rd(string req, logic [15:0] a, logic [1:0] l,
                      logic [8:0] t, output logic [63:0] d);
        @(negedge clk);
        put(1'b1, 1'b0, a, l, t, '0);
        @(negedge clk);
        idle();
        chk({req, " R2 valid"}, 64'(rsp_valid), 64'd1);
        chk({req, " R2 tag"}, 64'(rsp_tag), 64'(t));
        d = rsp_data;
    endtask

    task automatic wr(string req, logic [15:0] a, logic [1:0] l, logic [63:0] d);
        @(negedge clk);
        put(1'b0, 1'b1, a, l, 9'h0AA, d);
        @(negedge clk);
        idle();
        chk({req, " R2 no rsp on write"}, 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_reset();
        logic [63:0] d;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", 64'(rsp_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", 64'(rsp_valid), 64'd0);
        rd("R1 reg0", 16'd0, 2'd1, 9'h001, d);
        chk("R1 reg0 zero", d, 64'd0);
        rd("R1 status", 16'd16, 2'd1, 9'h002, d);
        chk("R1 err clear", d, 64'd0);
    endtask

    task automatic t_full_write();
        logic [63:0] d;
        wr("R6", 16'd2, 2'd1, 64'h1122_3344_5566_7788);
        rd("R4 reg1", 16'd2, 2'd1, 9'h155, d);
        chk("R6 R4 reg1 full", d, 64'h1122_3344_5566_7788);
    endtask

    task automatic t_half_write();
        logic [63:0] d;
        wr("R5 lo", 16'd0, 2'd0, 64'hDEAD_0000_AAAA_5555);
        wr("R5 hi", 16'd1, 2'd0, 64'hBEEF_0000_1234_5678);
        rd("R5 reg0", 16'd0, 2'd1, 9'h010, d);
        chk("R5 halves", d, 64'h1234_5678_AAAA_5555);
        rd("R3 odd", 16'd1, 2'd0, 9'h011, d);
        chk("R3 odd dword", d, 64'h0000_0000_1234_5678);
        rd("R3 even", 16'd0, 2'd0, 9'h012, d);
        chk("R3 even dword", d, 64'h0000_0000_AAAA_5555);
    endtask

    task automatic t_misalign();
        logic [63:0] d;
        wr("R7 odd write", 16'd3, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
        rd("R7 reg1 kept", 16'd2, 2'd1, 9'h020, d);
        chk("R7 reg1 unchanged", d, 64'h1122_3344_5566_7788);
        rd("R7 status", 16'd16, 2'd1, 9'h021, d);
        chk("R7 err set", d, 64'd1);
        rd("R7 odd read", 16'd5, 2'd1, 9'h1C3, d);
        chk("R7 odd read zero", d, 64'd0);
        wr("R8 status write", 16'd16, 2'd1, 64'h0);
        rd("R7 status sticky", 16'd16, 2'd1, 9'h022, d);
        chk("R7 R8 err still set", d, 64'd1);
    endtask

    task automatic t_map();
        logic [63:0] d;
        rd("R8 unmapped", 16'd80, 2'd1, 9'h030, d);
        chk("R8 unmapped zero", d, 64'd0);
        wr("R8 unmapped write", 16'd80, 2'd1, 64'h7777_7777_7777_7777);
        rd("R8 unmapped again", 16'd80, 2'd1, 9'h031, d);
        chk("R8 unmapped still zero", d, 64'd0);
        wr("R8 id write", 16'd32, 2'd1, 64'h0);
        rd("R9 id lo", 16'd32, 2'd1, 9'h032, d);
        chk("R9 id lo", d, ID_LO);
        rd("R9 id hi", 16'd34, 2'd1, 9'h033, d);
        chk("R9 id hi", d, ID_HI);
        rd("R9 id lo upper dword", 16'd33, 2'd0, 9'h034, d);
        chk("R9 R3 id lo upper", d, {32'd0, ID_LO[63:32]});
    endtask

    task automatic t_wide();
        logic [63:0] d;
        wr("R10 line write", 16'd4, 2'd2, 64'h9999_9999_9999_9999);
        wr("R10 rsvd write", 16'd4, 2'd3, 64'h8888_8888_8888_8888);
        rd("R10 reg2", 16'd4, 2'd1, 9'h040, d);
        chk("R10 reg2 untouched", d, 64'd0);
        rd("R10 line read", 16'd2, 2'd2, 9'h041, d);
        chk("R10 line read zero", d, 64'd0);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        put(1'b1, 1'b0, 16'd2, 2'd1, 9'h101, '0);
        @(negedge clk);
        chk("R11 rsp1 valid", 64'(rsp_valid), 64'd1);
        chk("R11 rsp1 tag", 64'(rsp_tag), 64'h101);
        chk("R11 rsp1 data", rsp_data, 64'h1122_3344_5566_7788);
        put(1'b0, 1'b1, 16'd6, 2'd1, 9'h0, 64'hCAFE_F00D_0BAD_BEEF);
        @(negedge clk);
        chk("R11 R2 no rsp for write", 64'(rsp_valid), 64'd0);
        put(1'b1, 1'b0, 16'd6, 2'd1, 9'h1FF, '0);
        @(negedge clk);
        chk("R11 rsp2 valid", 64'(rsp_valid), 64'd1);
        chk("R11 rsp2 tag", 64'(rsp_tag), 64'h1FF);
        chk("R11 write then read", rsp_data, 64'hCAFE_F00D_0BAD_BEEF);
        put(1'b1, 1'b0, 16'd7, 2'd0, 9'h0F0, '0);
        @(negedge clk);
        idle();
        chk("R11 rsp3 tag", 64'(rsp_tag), 64'h0F0);
        chk("R11 R3 rsp3 data", rsp_data, 64'h0000_0000_CAFE_F00D);
        @(negedge clk);
        chk("R11 R2 idle no rsp", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_full_write();
        t_half_write();
        t_misalign();
        t_map();
        t_wide();
        t_back_to_back();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule